// File: doc/BRIEF.md
# Kernel Dependency Scheduling Window

This block sits between a queue of launched compute kernels and a small pool of execution streams. Each kernel arrives as a descriptor with an identifier, up to two read address ranges, up to two write address ranges, and a flag that marks its memory footprint as unknown. Descriptors wait in an input FIFO. They move into an eight-entry window as soon as a slot is free. On entry, the new kernel is compared in one cycle against every kernel still held in the window. Each older kernel whose ranges conflict with the new one becomes an upstream kernel of it.

An entry with upstream kernels left is pending. An entry with none left is ready. An entry handed to a stream is executing. Each cycle the oldest ready entry goes to the lowest-numbered idle stream, and the stream sees a one-cycle start pulse together with the kernel identifier. When the stream raises its done line, the slot is released. In the same cycle, its bit is removed from the dependency record of every other entry, so the kernels that waited on it can become ready.

Top module: `kdw_window`

## Requirements
- R1: `in_ready` is high whenever the input FIFO holds fewer than FIFO_DEPTH descriptors. A descriptor is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- R2: Two ranges (base, length) overlap only when both lengths are non-zero, base_a < base_b+length_b and base_b < base_a+length_a. Adjacent ranges and zero-length ranges never create a dependency.
- R3: A kernel that reads a range overlapping a write range of an older kernel in the window waits until that kernel's stream reports done.
- R4: A kernel whose write range overlaps a read range or a write range of an older kernel in the window also waits for it. This applies to every segment slot.
- R5: A kernel marked unknown (`in_whole`=1) depends on every older kernel in the window. Every younger kernel depends on it until it completes.
- R6: An entry is dispatched only once every upstream kernel has completed. Kernels with no upstream kernel are dispatched without waiting for one another.
- R7: A stream holds at most one kernel. A start pulse is never issued to a stream that is still busy. Raising `st_done[s]` for one cycle releases stream s and its kernel's slot.
- R8: At most one start pulse is issued per cycle. The oldest ready kernel in arrival order is dispatched first, to the idle stream with the lowest index.
- R9: A completion removes the finished kernel from every dependency record in the same cycle. A kernel inserted in the same cycle as that completion does not depend on the finished kernel.
- R10: While all window slots are occupied, no descriptor leaves the FIFO. Descriptors queue in the FIFO until a slot frees.
- R11: After reset, `in_ready` is 1, no start pulse is issued and all streams are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | FIFO can accept a descriptor |
| in_id | input | 8 | Kernel identifier |
| in_whole | input | 1 | Footprint unknown: treat as whole memory |
| in_rd_base | input | 32 | Read range bases, slot n at bits [16n+15:16n] |
| in_rd_len | input | 32 | Read range lengths, same layout |
| in_wr_base | input | 32 | Write range bases, same layout |
| in_wr_len | input | 32 | Write range lengths, same layout |
| st_start | output | NUM_STREAMS | One-cycle start pulse per stream |
| st_id | output | NUM_STREAMS*8 | Kernel identifier per stream, stream s at bits [8s+7:8s] |
| st_done | input | NUM_STREAMS | Stream s finished its kernel |

## Verification
On every cycle, the bound checker enforces four rules. At most one start pulse appears, and no pulse goes to a stream the checker still sees as busy. `in_ready` agrees with a FIFO occupancy the checker counts independently. No insertion happens while the window is full. The bench's scenarios cover the rest: which kernel pairs the range comparison links (read-after-write, write-after-read, write-after-write, adjacent and zero-length ranges, unknown footprints), the oldest-first and lowest-stream order of dispatch, and a completion that lands in the same cycle as a dependent insertion. Only a full sequence of starts and completions can show these.

// File: rtl/kdw_pkg.sv
package kdw_pkg;

    localparam int ADDR_W  = 16;
    localparam int ID_W    = 8;
    localparam int RD_SEGS = 2;
    localparam int WR_SEGS = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] len;
    } seg_t;

    typedef struct packed {
        logic [ID_W-1:0]         id;
        logic                    whole;
        seg_t [RD_SEGS-1:0]      rd;
        seg_t [WR_SEGS-1:0]      wr;
    } kdesc_t;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_EXEC = 2'd2
    } slot_st_t;

    // Half-open interval test; an empty range never collides.
    function automatic logic seg_hit(seg_t a, seg_t b);
        logic [ADDR_W:0] a_end;
        logic [ADDR_W:0] b_end;
        a_end = {1'b0, a.base} + {1'b0, a.len};
        b_end = {1'b0, b.base} + {1'b0, b.len};
        if (a.len == '0 || b.len == '0) begin
            return 1'b0;
        end
        return ({1'b0, a.base} < b_end) && ({1'b0, b.base} < a_end);
    endfunction

    // Does the younger descriptor y have to wait for the older one o?
    function automatic logic desc_conflict(kdesc_t y, kdesc_t o);
        logic hit;
        hit = y.whole || o.whole;
        for (int r = 0; r < RD_SEGS; r++) begin
            for (int w = 0; w < WR_SEGS; w++) begin
                hit = hit || seg_hit(y.rd[r], o.wr[w]) || seg_hit(y.wr[w], o.rd[r]);
            end
        end
        for (int w = 0; w < WR_SEGS; w++) begin
            for (int v = 0; v < WR_SEGS; v++) begin
                hit = hit || seg_hit(y.wr[w], o.wr[v]);
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/kdw_fifo.sv
module kdw_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          push_ok;
    logic          pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop_ok) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/kdw_dep_check.sv
module kdw_dep_check
    import kdw_pkg::*;
#(
    parameter int WIN = 8
) (
    input  kdesc_t               cand,
    input  kdesc_t [WIN-1:0]     ents,
    input  logic   [WIN-1:0]     live,
    output logic   [WIN-1:0]     deps
);
    for (genvar g = 0; g < WIN; g++) begin : g_cmp
        assign deps[g] = live[g] && desc_conflict(cand, ents[g]);
    end
endmodule

// File: rtl/kdw_pick.sv
module kdw_pick #(
    parameter int WIN = 8,
    parameter int NS  = 3,
    parameter int IW  = (WIN > 1) ? $clog2(WIN) : 1,
    parameter int SW  = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [WIN-1:0]          rdy,
    input  logic [WIN-1:0][WIN-1:0] older,
    input  logic [NS-1:0]           busy,
    output logic                    go,
    output logic [IW-1:0]           idx,
    output logic [SW-1:0]           sid
);
    logic [WIN-1:0] oldest;
    logic           e_found;
    logic           s_found;

    // An entry is oldest when no other ready entry precedes it.
    for (genvar g = 0; g < WIN; g++) begin : g_age
        assign oldest[g] = rdy[g] && ((rdy & older[g]) == '0);
    end

    always_comb begin
        idx     = '0;
        e_found = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            if (oldest[i] && !e_found) begin
                idx     = IW'(i);
                e_found = 1'b1;
            end
        end
        sid     = '0;
        s_found = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (!busy[s] && !s_found) begin
                sid     = SW'(s);
                s_found = 1'b1;
            end
        end
        go = e_found && s_found;
    end
endmodule

// File: rtl/kdw_window.sv
module kdw_window
    import kdw_pkg::*;
#(
    parameter int WIN_DEPTH   = 8,
    parameter int NUM_STREAMS = 3,
    parameter int FIFO_DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [ID_W-1:0]               in_id,
    input  logic                          in_whole,
    input  logic [RD_SEGS*ADDR_W-1:0]     in_rd_base,
    input  logic [RD_SEGS*ADDR_W-1:0]     in_rd_len,
    input  logic [WR_SEGS*ADDR_W-1:0]     in_wr_base,
    input  logic [WR_SEGS*ADDR_W-1:0]     in_wr_len,
    output logic [NUM_STREAMS-1:0]        st_start,
    output logic [NUM_STREAMS*ID_W-1:0]   st_id,
    input  logic [NUM_STREAMS-1:0]        st_done
);
    localparam int IW = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;
    localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;
    localparam int DW = $bits(kdesc_t);

    // ---------------- input descriptor and FIFO ----------------
    kdesc_t          in_desc;
    logic [DW-1:0]   fifo_q;
    kdesc_t          head;
    logic            fifo_full;
    logic            fifo_empty;
    logic            win_ins;
    logic            win_full;

    always_comb begin
        in_desc.id    = in_id;
        in_desc.whole = in_whole;
        for (int r = 0; r < RD_SEGS; r++) begin
            in_desc.rd[r].base = in_rd_base[r*ADDR_W +: ADDR_W];
            in_desc.rd[r].len  = in_rd_len[r*ADDR_W +: ADDR_W];
        end
        for (int w = 0; w < WR_SEGS; w++) begin
            in_desc.wr[w].base = in_wr_base[w*ADDR_W +: ADDR_W];
            in_desc.wr[w].len  = in_wr_len[w*ADDR_W +: ADDR_W];
        end
    end

    kdw_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (in_valid),
        .din   (in_desc),
        .full  (fifo_full),
        .pop   (win_ins),
        .dout  (fifo_q),
        .empty (fifo_empty)
    );

    assign in_ready = !fifo_full;
    assign head     = fifo_q;

    // ---------------- window state ----------------
    slot_st_t                            slot_st [WIN_DEPTH];
    kdesc_t   [WIN_DEPTH-1:0]            slot_d;
    logic     [WIN_DEPTH-1:0][WIN_DEPTH-1:0] slot_dep;
    logic     [WIN_DEPTH-1:0][WIN_DEPTH-1:0] slot_older;
    logic     [NUM_STREAMS-1:0]          str_busy;
    logic     [IW-1:0]                   str_slot [NUM_STREAMS];

    logic [WIN_DEPTH-1:0] used;
    logic [WIN_DEPTH-1:0] rdy;
    logic [WIN_DEPTH-1:0] fin;
    logic [WIN_DEPTH-1:0] live;
    logic [WIN_DEPTH-1:0] new_dep;
    logic [IW-1:0]        alloc_idx;
    logic                 alloc_ok;
    logic                 go;
    logic [IW-1:0]        pick_idx;
    logic [SW-1:0]        pick_sid;

    // Slots whose kernel completes this cycle.
    always_comb begin
        fin = '0;
        for (int s = 0; s < NUM_STREAMS; s++) begin
            if (st_done[s] && str_busy[s]) begin
                fin[str_slot[s]] = 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < WIN_DEPTH; i++) begin
            used[i] = (slot_st[i] != SLOT_FREE);
            rdy[i]  = (slot_st[i] == SLOT_WAIT) && (slot_dep[i] == '0);
        end
    end

    assign live = used & ~fin;

    always_comb begin
        alloc_idx = '0;
        alloc_ok  = 1'b0;
        for (int i = 0; i < WIN_DEPTH; i++) begin
            if (!used[i] && !alloc_ok) begin
                alloc_idx = IW'(i);
                alloc_ok  = 1'b1;
            end
        end
    end

    assign win_full = !alloc_ok;
    assign win_ins  = !fifo_empty && alloc_ok;

    kdw_dep_check #(.WIN(WIN_DEPTH)) u_dep (
        .cand (head),
        .ents (slot_d),
        .live (live),
        .deps (new_dep)
    );

    kdw_pick #(.WIN(WIN_DEPTH), .NS(NUM_STREAMS), .IW(IW), .SW(SW)) u_pick (
        .rdy   (rdy),
        .older (slot_older),
        .busy  (str_busy),
        .go    (go),
        .idx   (pick_idx),
        .sid   (pick_sid)
    );

    always_ff @(posedge clk) begin
        if (win_ins) begin
            slot_d[alloc_idx] <= head;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WIN_DEPTH; i++) begin
                slot_st[i]    <= SLOT_FREE;
                slot_dep[i]   <= '0;
                slot_older[i] <= '0;
            end
        end else begin
            for (int i = 0; i < WIN_DEPTH; i++) begin
                slot_dep[i]   <= slot_dep[i] & ~fin;
                slot_older[i] <= slot_older[i] & ~fin;
                if (fin[i]) begin
                    slot_st[i] <= SLOT_FREE;
                end
                if (go && pick_idx == IW'(i)) begin
                    slot_st[i] <= SLOT_EXEC;
                end
                if (win_ins && alloc_idx == IW'(i)) begin
                    slot_st[i]    <= SLOT_WAIT;
                    slot_dep[i]   <= new_dep;
                    slot_older[i] <= live;
                end
            end
        end
    end

    // ---------------- streams ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            str_busy <= '0;
            st_start <= '0;
            st_id    <= '0;
            for (int s = 0; s < NUM_STREAMS; s++) begin
                str_slot[s] <= '0;
            end
        end else begin
            st_start <= '0;
            for (int s = 0; s < NUM_STREAMS; s++) begin
                if (st_done[s]) begin
                    str_busy[s] <= 1'b0;
                end
                if (go && pick_sid == SW'(s)) begin
                    str_busy[s]                <= 1'b1;
                    str_slot[s]                <= pick_idx;
                    st_start[s]                <= 1'b1;
                    st_id[s*ID_W +: ID_W]      <= slot_d[pick_idx].id;
                end
            end
        end
    end

endmodule

// File: rtl/kdw_window_chk.sv
module kdw_window_chk #(
    parameter int NS = 3,
    parameter int FD = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          win_ins,
    input logic          win_full,
    input logic [NS-1:0] st_start,
    input logic [NS-1:0] st_done
);
    localparam int CW = $clog2(FD + 1) + 1;

    logic [NS-1:0] sb;
    logic [CW-1:0] occ;
    logic          acc;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            sb  <= '0;
            occ <= '0;
        end else begin
            sb <= (sb & ~st_done) | st_start;
            case ({acc, win_ins})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    p_ready_tracks_r1: assert property (@(posedge clk) disable iff (rst)
        in_ready == (occ < CW'(FD)));

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(FD));

    p_idle_start_r7: assert property (@(posedge clk) disable iff (rst)
        (st_start & sb) == '0);

    p_one_start_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_start));

    p_full_stall_r10: assert property (@(posedge clk) disable iff (rst)
        win_full |-> !win_ins);

    p_quiet_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_start == '0));

endmodule

bind kdw_window kdw_window_chk #(.NS(NUM_STREAMS), .FD(FIFO_DEPTH)) u_kdw_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .win_ins  (win_ins),
    .win_full (win_full),
    .st_start (st_start),
    .st_done  (st_done)
);

// File: tb/kdw_window_bench.sv
module kdw_window_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_id = '0;
    logic          in_whole = 1'b0;
    logic [31:0]   in_rd_base = '0;
    logic [31:0]   in_rd_len = '0;
    logic [31:0]   in_wr_base = '0;
    logic [31:0]   in_wr_len = '0;
    logic [NS-1:0] st_start;
    logic [NS*8-1:0] st_id;
    logic [NS-1:0] st_done = '0;

    int checks = 0;
    int fails  = 0;
    int    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    kdw_window #(.WIN_DEPTH(8), .NUM_STREAMS(NS), .FIFO_DEPTH(4)) u_kdw_window (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_id(in_id), .in_whole(in_whole),
        .in_rd_base(in_rd_base), .in_rd_len(in_rd_len),
        .in_wr_base(in_wr_base), .in_wr_len(in_wr_len),
        .st_start(st_start), .st_id(st_id), .st_done(st_done)
    );

    // Monitor: every start pulse must match the head of the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            for (int s = 0; s < NS; s++) begin
                if (st_start[s]) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R6: unexpected start stream %0d id %0d, expected none",
                                 s, st_id[s*8 +: 8]);
                    end else begin
                        int    e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (e != s*256 + int'(st_id[s*8 +: 8])) begin
                            fails++;
                            $display("FAIL %s: stream %0d id %0d, expected stream %0d id %0d",
                                     t, s, st_id[s*8 +: 8], e / 256, e % 256);
                        end
                    end
                end
            end
        end
    end

    task automatic expect_start(input int s, input int id, input string req);
        exp_q.push_back(s*256 + id);
        tag_q.push_back(req);
    endtask

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // seg = {base[15:0], len[15:0]}
    task automatic push(input int id, input bit whole,
                        input logic [31:0] r0, input logic [31:0] r1,
                        input logic [31:0] w0, input logic [31:0] w1);
        @(negedge clk);
        in_id      = id[7:0];
        in_whole   = whole;
        in_rd_base = {r1[31:16], r0[31:16]};
        in_rd_len  = {r1[15:0],  r0[15:0]};
        in_wr_base = {w1[31:16], w0[31:16]};
        in_wr_len  = {w1[15:0],  w0[15:0]};
        in_valid   = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish(input logic [NS-1:0] m);
        @(negedge clk);
        st_done = m;
        @(negedge clk);
        st_done = '0;
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 60 && exp_q.size() != 0; k++) @(negedge clk);
        check(req, exp_q.size() == 0, exp_q.size(), 0);
    endtask

    task automatic quiet(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check("R11", in_ready == 1'b1, in_ready, 1);
        check("R11", st_start == '0, st_start, 0);

        // R8 / R2: independent kernels, adjacent ranges, in order to streams 0,1,2
        expect_start(0, 1, "R8");
        expect_start(1, 2, "R2");
        expect_start(2, 3, "R8");
        push(1, 0, 32'h0, 32'h0, 32'h0000_0010, 32'h0);
        push(2, 0, 32'h0010_0004, 32'h0, 32'h0, 32'h0);
        push(3, 0, 32'h0, 32'h0, 32'h0020_0008, 32'h0);
        drain("R8");
        finish(3'b111);

        // R3: read after write on the last byte waits for completion
        expect_start(0, 4, "R3");
        push(4, 0, 32'h0, 32'h0, 32'h0100_0010, 32'h0);
        push(5, 0, 32'h010F_0001, 32'h0, 32'h0, 32'h0);
        drain("R3");
        quiet(10);
        expect_start(0, 5, "R3");
        finish(3'b001);
        drain("R3");
        finish(3'b001);

        // R4: write after read
        expect_start(0, 6, "R4");
        push(6, 0, 32'h0200_0008, 32'h0, 32'h0, 32'h0);
        push(7, 0, 32'h0, 32'h0, 32'h0207_0002, 32'h0);
        drain("R4");
        quiet(10);
        expect_start(0, 7, "R4");
        finish(3'b001);
        drain("R4");
        finish(3'b001);

        // R4: write after write through the second write slot
        expect_start(0, 8, "R4");
        push(8, 0, 32'h0, 32'h0, 32'h0300_0004, 32'h0);
        push(9, 0, 32'h0, 32'h0, 32'h0, 32'h0302_0004);
        drain("R4");
        quiet(10);
        expect_start(0, 9, "R4");
        finish(3'b001);
        drain("R4");
        finish(3'b001);

        // R2: zero-length write inside a read range creates no dependency
        expect_start(0, 10, "R2");
        expect_start(1, 11, "R2");
        push(10, 0, 32'h0, 32'h0, 32'h0402_0000, 32'h0500_0004);
        push(11, 0, 32'h0400_0004, 32'h0, 32'h0, 32'h0);
        drain("R2");
        finish(3'b011);

        // R5: unknown footprint waits for a read-only kernel, and blocks a later one
        expect_start(0, 12, "R5");
        push(12, 0, 32'h0600_0004, 32'h0, 32'h0, 32'h0);
        push(13, 1, 32'h0, 32'h0, 32'h0, 32'h0);
        push(14, 0, 32'h0700_0004, 32'h0, 32'h0, 32'h0);
        drain("R5");
        quiet(10);
        expect_start(0, 13, "R5");
        finish(3'b001);
        drain("R5");
        quiet(10);
        expect_start(0, 14, "R6");
        finish(3'b001);
        drain("R6");
        finish(3'b001);

        // R8 / R7: all streams busy, then oldest ready goes to the freed stream
        expect_start(0, 15, "R7");
        expect_start(1, 16, "R7");
        expect_start(2, 17, "R7");
        push(15, 0, 32'h0, 32'h0, 32'h0A00_0004, 32'h0);
        push(16, 0, 32'h0, 32'h0, 32'h0A10_0004, 32'h0);
        push(17, 0, 32'h0, 32'h0, 32'h0A20_0004, 32'h0);
        drain("R7");
        push(18, 0, 32'h0, 32'h0, 32'h0B00_0004, 32'h0);
        push(19, 0, 32'h0, 32'h0, 32'h0B10_0004, 32'h0);
        push(20, 0, 32'h0, 32'h0, 32'h0B20_0004, 32'h0);
        quiet(10);
        expect_start(1, 18, "R8");
        finish(3'b010);
        drain("R8");
        expect_start(0, 19, "R8");
        expect_start(2, 20, "R8");
        finish(3'b101);
        drain("R8");
        finish(3'b111);

        // R9: completion in the same cycle as a dependent insertion
        expect_start(0, 21, "R9");
        push(21, 0, 32'h0, 32'h0, 32'h0800_0008, 32'h0);
        drain("R9");
        expect_start(0, 22, "R9");
        push(22, 0, 32'h0800_0004, 32'h0, 32'h0, 32'h0);
        st_done = 3'b001;
        @(negedge clk);
        st_done = '0;
        drain("R9");
        finish(3'b001);

        // R10 / R1: window full, FIFO full, then serial release
        expect_start(0, 30, "R10");
        for (int k = 0; k < 12; k++) begin
            push(30 + k, 1, 32'h0, 32'h0, 32'h0, 32'h0);
        end
        quiet(5);
        check("R10", in_ready == 1'b0, in_ready, 0);
        drain("R10");
        for (int k = 1; k < 12; k++) begin
            expect_start(0, 30 + k, "R10");
            finish(3'b001);
            drain("R10");
            if (k == 1) begin
                check("R1", in_ready == 1'b1, in_ready, 1);
            end
        end
        finish(3'b001);
        quiet(5);
        check("R1", in_ready == 1'b1, in_ready, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule